// File: doc/BRIEF.md
# DMA Channel Register File with Byte-Pointer Access

This block is the host-facing register set of a four-channel DMA controller. The host reaches it through an 8-bit port bus. Each channel has a 16-bit base and current address, a 16-bit base and current count, an 8-bit page byte, a mode field, a mask bit and a software request bit. Every 16-bit register sits behind a single 8-bit port. One byte-pointer flip-flop, shared by all eight address and count ports, decides whether an access hits the low byte or the high byte. The host resets that pointer by writing a dedicated port. Mask and request bits are set or cleared one channel at a time, with a single encoded byte.

The transfer engine reads the channel state from the output ports. It reports each completed transfer on a step strobe, naming the channel. The block then moves the current address up or down by one and lowers the current count by one. When a step arrives with the count already at zero, the channel has reached terminal count: the block raises a one-cycle terminal pulse and either reloads the channel or leaves it masked. The page byte is never touched by stepping, so a transfer stays inside one 64 Ki window.

Top module: `dmareg_top`

## Requirements
- R1: After reset the byte pointer is low, every mask bit is 1, every request bit is 0, and every mode, address, count and page register is 0.
- R2: Any write to port 11 clears the byte pointer, so the next address or count access uses the low byte.
- R3: Channel n's address is at port 2n and its count at port 2n+1. Each read or write of ports 0 to 7 uses the low byte when the shared pointer is 0 and the high byte when it is 1, then toggles the pointer. The pointer is shared by all eight ports.
- R4: A write to an address or count port loads the selected byte of both the base and the current register. A read returns the current register.
- R5: A write to port 8 changes the mask bit of the channel in data bits [1:0], setting it when bit 2 is 1 and clearing it when bit 2 is 0. A read of port 8 returns the four mask bits in [3:0], one bit per channel.
- R6: A write to port 9 uses the same format for the software request bits. A read of port 9 returns them in [3:0].
- R7: A write to port 10 updates the mode of the channel in bits [1:0]. Bits [3:2] give the direction (0 verify, 1 write, 2 read), bit 4 enables auto-reload, bit 5 selects decrement, and bits [7:6] give the transfer type (0 demand, 1 single, 2 block, 3 cascade). The written bits [7:2] appear on mode_o[6i+5:6i] for channel i.
- R8: Page ports 12 to 15 are read and written directly and hold address bits [23:16] of channels 0 to 3. No step changes a page byte; the current address wraps within 16 bits.
- R9: A step on a channel moves its current address by +1, or by -1 when decrement is selected, and lowers its current count by 1. The count therefore holds the number of transfers left minus one.
- R10: A step that arrives while the count is 0 raises tc_o for that channel for one cycle and clears its request bit. Without auto-reload the count becomes FFFF and the mask bit is set. With auto-reload the current address and count are reloaded from base and the mask bit is left as it was.
- R11: bus_rdata is 0 while bus_rd is low, and reads of ports 10 and 11 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe |
| bus_port | input | 4 | Port number |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| step_valid | input | 1 | Engine finished one transfer |
| step_chan | input | 2 | Channel of that transfer |
| mask_o | output | 4 | Mask bit per channel |
| req_o | output | 4 | Software request bit per channel |
| mode_o | output | 24 | Six mode bits per channel |
| page_o | output | 32 | Page byte per channel |
| cur_addr_o | output | 64 | Current address per channel |
| cur_cnt_o | output | 64 | Current count per channel |
| tc_o | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
Read data is combinational: it is valid in the same cycle as bus_rd. The bench therefore samples it one time unit after driving the read, before the clock edge that toggles the pointer. Every write and every step takes effect at the next rising edge, and tc_o rises at that same edge. The bench samples registers and tc_o shortly after that edge, then once more one edge later to confirm the pulse has gone. Pointer sharing is shown by writing one channel's address and then another channel's count without a clear in between.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);
  localparam int DW = 8;
  localparam int RW = 2 * DW;
  localparam int PW = 4;
  localparam int MW = DW - CHW;

  localparam logic [PW-1:0] P_MASK  = PW'(2 * NCH);
  localparam logic [PW-1:0] P_REQ   = PW'(2 * NCH + 1);
  localparam logic [PW-1:0] P_MODE  = PW'(2 * NCH + 2);
  localparam logic [PW-1:0] P_CLRFF = PW'(2 * NCH + 3);
  localparam logic [PW-1:0] P_PAGE0 = PW'(2 * NCH + 4);

  typedef enum logic [1:0] {XF_DEMAND, XF_SINGLE, XF_BLOCK, XF_CASCADE} xfer_e;
  typedef enum logic [1:0] {DIR_VERIFY, DIR_WRITE, DIR_READ, DIR_RSVD} dir_e;

  typedef struct packed {
    xfer_e xfer;
    logic  decr;
    logic  autoinit;
    dir_e  dir;
  } mode_t;

  function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] word,
                                             input logic hi,
                                             input logic [DW-1:0] b);
    return hi ? {b, word[DW-1:0]} : {word[RW-1:DW], b};
  endfunction

  function automatic logic [DW-1:0] get_byte(input logic [RW-1:0] word, input logic hi);
    return hi ? word[RW-1:DW] : word[DW-1:0];
  endfunction

  function automatic logic [RW-1:0] addr_step(input logic [RW-1:0] a, input logic decr);
    return decr ? a - RW'(1) : a + RW'(1);
  endfunction

  function automatic logic [RW-1:0] cnt_step(input logic [RW-1:0] c);
    return c - RW'(1);
  endfunction

  function automatic logic cnt_is_term(input logic [RW-1:0] c);
    return c == '0;
  endfunction
endpackage

// File: rtl/dmareg_byteptr.sv
module dmareg_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic toggle,
  output logic hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi <= 1'b0;
    else if (clr)    hi <= 1'b0;
    else if (toggle) hi <= ~hi;
  end
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic          cnt_wr,
  input  logic          hi_byte,
  input  logic [DW-1:0] wdata,
  input  logic          mode_wr,
  input  logic          mask_wr,
  input  logic          req_wr,
  input  logic          page_wr,
  input  logic          step,
  output logic [RW-1:0] cur_addr,
  output logic [RW-1:0] cur_cnt,
  output logic [DW-1:0] page,
  output mode_t         mode,
  output logic          mask,
  output logic          req,
  output logic          tc
);
  logic [RW-1:0] base_addr;
  logic [RW-1:0] base_cnt;
  logic          step_term;
  logic          reload;

  assign step_term = step && cnt_is_term(cur_cnt);
  assign reload    = step_term && mode.autoinit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      page      <= '0;
      mode      <= '0;
      mask      <= 1'b1;
      req       <= 1'b0;
      tc        <= 1'b0;
    end else begin
      tc <= step_term;
      if (addr_wr) begin
        base_addr <= put_byte(base_addr, hi_byte, wdata);
        cur_addr  <= put_byte(cur_addr, hi_byte, wdata);
      end else if (reload) begin
        cur_addr <= base_addr;
      end else if (step) begin
        cur_addr <= addr_step(cur_addr, mode.decr);
      end
      if (cnt_wr) begin
        base_cnt <= put_byte(base_cnt, hi_byte, wdata);
        cur_cnt  <= put_byte(cur_cnt, hi_byte, wdata);
      end else if (reload) begin
        cur_cnt <= base_cnt;
      end else if (step) begin
        cur_cnt <= cnt_step(cur_cnt);
      end
      if (mode_wr) mode <= mode_t'(wdata[DW-1:CHW]);
      if (page_wr) page <= wdata;
      if (mask_wr) mask <= wdata[CHW];
      else if (step_term && !mode.autoinit) mask <= 1'b1;
      if (req_wr) req <= wdata[CHW];
      else if (step_term) req <= 1'b0;
    end
  end

  // R8
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !page_wr) |=> page == $past(page));

  // R10
  tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> ($past(step) && $past(cur_cnt) == '0));

  // R4
  load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !hi_byte) |=> (cur_addr[DW-1:0] == $past(wdata) && base_addr[DW-1:0] == $past(wdata)));

  // R10
  reload_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_cnt == '0 && mode.autoinit && !mask_wr) |=> mask == $past(mask));
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PW-1:0]     bus_port,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              step_valid,
  input  logic [CHW-1:0]    step_chan,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    req_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic [NCH*DW-1:0] page_o,
  output logic [NCH*RW-1:0] cur_addr_o,
  output logic [NCH*RW-1:0] cur_cnt_o,
  output logic [NCH-1:0]    tc_o
);
  logic          is_reg_port;
  logic          ptr_acc;
  logic          ptr_clr;
  logic          ptr_hi;
  logic [CHW-1:0] reg_ch;
  logic [CHW-1:0] sel_ch;
  logic [RW-1:0] addr_arr [NCH];
  logic [RW-1:0] cnt_arr  [NCH];
  logic [DW-1:0] page_arr [NCH];
  logic [DW-1:0] rd_mux;

  assign is_reg_port = (bus_port < PW'(2 * NCH));
  assign ptr_acc     = (bus_wr || bus_rd) && is_reg_port;
  assign ptr_clr     = bus_wr && (bus_port == P_CLRFF);
  assign reg_ch      = bus_port[CHW:1];
  assign sel_ch      = bus_wdata[CHW-1:0];

  dmareg_byteptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (ptr_clr),
    .toggle (ptr_acc),
    .hi     (ptr_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic  a_wr, c_wr, m_wr, k_wr, r_wr, p_wr, stp;
    mode_t md;
    assign a_wr = bus_wr && is_reg_port && reg_ch == CHW'(i) && !bus_port[0];
    assign c_wr = bus_wr && is_reg_port && reg_ch == CHW'(i) && bus_port[0];
    assign m_wr = bus_wr && bus_port == P_MODE && sel_ch == CHW'(i);
    assign k_wr = bus_wr && bus_port == P_MASK && sel_ch == CHW'(i);
    assign r_wr = bus_wr && bus_port == P_REQ && sel_ch == CHW'(i);
    assign p_wr = bus_wr && bus_port == P_PAGE0 + PW'(i);
    assign stp  = step_valid && step_chan == CHW'(i);

    dmareg_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_wr  (a_wr),
      .cnt_wr   (c_wr),
      .hi_byte  (ptr_hi),
      .wdata    (bus_wdata),
      .mode_wr  (m_wr),
      .mask_wr  (k_wr),
      .req_wr   (r_wr),
      .page_wr  (p_wr),
      .step     (stp),
      .cur_addr (addr_arr[i]),
      .cur_cnt  (cnt_arr[i]),
      .page     (page_arr[i]),
      .mode     (md),
      .mask     (mask_o[i]),
      .req      (req_o[i]),
      .tc       (tc_o[i])
    );

    assign mode_o[i*MW +: MW]     = md;
    assign page_o[i*DW +: DW]     = page_arr[i];
    assign cur_addr_o[i*RW +: RW] = addr_arr[i];
    assign cur_cnt_o[i*RW +: RW]  = cnt_arr[i];
  end

  always_comb begin
    rd_mux = '0;
    if (is_reg_port) begin
      rd_mux = bus_port[0] ? get_byte(cnt_arr[reg_ch], ptr_hi)
                           : get_byte(addr_arr[reg_ch], ptr_hi);
    end else if (bus_port >= P_PAGE0) begin
      rd_mux = page_arr[bus_port[CHW-1:0]];
    end else if (bus_port == P_MASK) begin
      rd_mux = {{(DW-NCH){1'b0}}, mask_o};
    end else if (bus_port == P_REQ) begin
      rd_mux = {{(DW-NCH){1'b0}}, req_o};
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;

  // R2
  clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !ptr_hi);

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_acc |=> ptr_hi != $past(ptr_hi));

  // R10
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_o));

  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_port == P_MASK) |=> mask_o[$past(sel_ch)] == $past(bus_wdata[CHW]));
endmodule

// File: tb/dmareg_top_tb.sv
module dmareg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_port = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        step_valid = 1'b0;
  logic [1:0]  step_chan = '0;
  logic [3:0]  mask_o, req_o, tc_o;
  logic [23:0] mode_o;
  logic [31:0] page_o;
  logic [63:0] cur_addr_o, cur_cnt_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dmareg_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .step_valid(step_valid), .step_chan(step_chan), .mask_o(mask_o),
    .req_o(req_o), .mode_o(mode_o), .page_o(page_o),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o), .tc_o(tc_o)
  );

  // {op (1 = read and compare), port, write data, expected read data}
  localparam int NV = 37;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd11, 8'h00, 8'h00}, {1'b0, 4'd0, 8'h34, 8'h00},
    {1'b0, 4'd0, 8'h12, 8'h00},  {1'b0, 4'd1, 8'h05, 8'h00},
    {1'b0, 4'd1, 8'h00, 8'h00},  {1'b0, 4'd11, 8'h00, 8'h00},
    {1'b1, 4'd0, 8'h00, 8'h34},  {1'b1, 4'd0, 8'h00, 8'h12},
    {1'b1, 4'd1, 8'h00, 8'h05},  {1'b1, 4'd1, 8'h00, 8'h00},
    {1'b0, 4'd2, 8'hCD, 8'h00},  {1'b0, 4'd3, 8'hAB, 8'h00},
    {1'b0, 4'd11, 8'h00, 8'h00}, {1'b1, 4'd3, 8'h00, 8'h00},
    {1'b1, 4'd3, 8'h00, 8'hAB},  {1'b1, 4'd2, 8'h00, 8'hCD},
    {1'b1, 4'd2, 8'h00, 8'h00},  {1'b1, 4'd8, 8'h00, 8'h0F},
    {1'b0, 4'd8, 8'h01, 8'h00},  {1'b1, 4'd8, 8'h00, 8'h0D},
    {1'b0, 4'd8, 8'h05, 8'h00},  {1'b1, 4'd8, 8'h00, 8'h0F},
    {1'b0, 4'd8, 8'h00, 8'h00},  {1'b1, 4'd8, 8'h00, 8'h0E},
    {1'b0, 4'd8, 8'h03, 8'h00},  {1'b1, 4'd8, 8'h00, 8'h06},
    {1'b0, 4'd9, 8'h06, 8'h00},  {1'b1, 4'd9, 8'h00, 8'h04},
    {1'b0, 4'd9, 8'h04, 8'h00},  {1'b1, 4'd9, 8'h00, 8'h05},
    {1'b0, 4'd9, 8'h02, 8'h00},  {1'b1, 4'd9, 8'h00, 8'h01},
    {1'b0, 4'd13, 8'h7A, 8'h00}, {1'b1, 4'd13, 8'h00, 8'h7A},
    {1'b1, 4'd12, 8'h00, 8'h00}, {1'b1, 4'd10, 8'h00, 8'h00},
    {1'b1, 4'd11, 8'h00, 8'h00}
  };

  function automatic string tag_of(input logic [3:0] p);
    if (p < 4'd8)  return "R3/R4 byte access";
    if (p == 4'd8) return "R5 mask";
    if (p == 4'd9) return "R6 request";
    if (p >= 4'd12) return "R8 page";
    return "R11 zero read";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] d);
    bus_wr = 1'b1; bus_port = p; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] p, output logic [7:0] d);
    bus_rd = 1'b1; bus_port = p;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic stp(input logic [1:0] c);
    step_valid = 1'b1; step_chan = c;
    @(posedge clk); #1;
    step_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 mask", mask_o, 64'hF);
    chk("R1 req", req_o, 64'h0);
    chk("R1 mode", mode_o, 64'h0);
    chk("R1 addr", cur_addr_o, 64'h0);
    chk("R1 count", cur_cnt_o, 64'h0);
    chk("R1 tc", tc_o, 64'h0);
    // R11 no read strobe
    bus_port = 4'd8; #1;
    chk("R11 idle rdata", bus_rdata, 64'h0);
    @(posedge clk); #1;

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][20]) begin
        rd(VEC[k][19:16], d);
        chk(tag_of(VEC[k][19:16]), d, VEC[k][7:0]);
      end else begin
        wr(VEC[k][19:16], VEC[k][15:8]);
      end
    end

    // R7 mode on channel 2: block, decrement, no reload, read
    wr(4'd10, 8'hAA);
    chk("R7 mode ch2", mode_o[17:12], 64'h2A);
    chk("R7 mode ch0 untouched", mode_o[5:0], 64'h0);
    wr(4'd9, 8'h06);
    wr(4'd8, 8'h02);
    chk("R6 req set ch2", req_o, 64'h5);
    chk("R5 mask clr ch2", mask_o, 64'h2);
    wr(4'd11, 8'h00);
    wr(4'd4, 8'h01); wr(4'd4, 8'h00);
    wr(4'd5, 8'h02); wr(4'd5, 8'h00);
    wr(4'd14, 8'h33);
    chk("R4 ch2 addr", cur_addr_o[47:32], 64'h0001);
    chk("R4 ch2 count", cur_cnt_o[47:32], 64'h0002);
    stp(2'd2);
    chk("R9 decr addr", cur_addr_o[47:32], 64'h0000);
    chk("R9 count", cur_cnt_o[47:32], 64'h0001);
    stp(2'd2);
    chk("R8 addr wraps", cur_addr_o[47:32], 64'hFFFF);
    chk("R8 page held", page_o[23:16], 64'h33);
    chk("R10 no early tc", tc_o, 64'h0);
    stp(2'd2);
    chk("R10 tc ch2", tc_o, 64'h4);
    chk("R10 count FFFF", cur_cnt_o[47:32], 64'hFFFF);
    chk("R9 addr moved", cur_addr_o[47:32], 64'hFFFE);
    chk("R10 mask set", mask_o, 64'h6);
    chk("R10 req cleared", req_o, 64'h1);
    chk("R8 page after tc", page_o[23:16], 64'h33);
    @(posedge clk); #1;
    chk("R10 tc one cycle", tc_o, 64'h0);

    // R10 auto-reload on channel 0, incrementing
    wr(4'd10, 8'h14);
    chk("R7 mode ch0", mode_o[5:0], 64'h05);
    wr(4'd11, 8'h00);
    wr(4'd1, 8'h01); wr(4'd1, 8'h00);
    stp(2'd0);
    chk("R9 incr addr", cur_addr_o[15:0], 64'h1235);
    chk("R9 count to 0", cur_cnt_o[15:0], 64'h0000);
    stp(2'd0);
    chk("R10 tc ch0", tc_o, 64'h1);
    chk("R10 reload addr", cur_addr_o[15:0], 64'h1234);
    chk("R10 reload count", cur_cnt_o[15:0], 64'h0001);
    chk("R10 mask kept", mask_o, 64'h6);
    chk("R10 req cleared ch0", req_o, 64'h0);
    wr(4'd11, 8'h00);
    rd(4'd1, d); chk("R4 read count low", d, 64'h01);
    rd(4'd0, d); chk("R3 shared pointer high", d, 64'h12);
    wr(4'd11, 8'h00);
    rd(4'd0, d); chk("R2 low after clear", d, 64'h34);
    finish_run();
  end
endmodule